// File: doc/BRIEF.md
# Variable-Length Instruction Prefix Decoder

This block sits at the front of an instruction fetch path. It accepts an instruction stream one byte per handshake, and the bytes arrive in order, byte aligned. An instruction may open with an optional control byte, the prefix. A byte counts as a prefix when its three low bits are all ones. The prefix carries the addressing-mode select, the register/operand width and the extension-set select. The opcode is always the next single byte. If the first byte is not a prefix, that byte is the opcode and every control field reads as zero.

Whether the opcode carries an operand is decided elsewhere. An upstream table supplies that fact on a sideband input alongside the opcode byte. When an operand is present, the block gathers 1, 2, 4 or 8 further bytes according to the width field. The first of these bytes is the least significant, and the block builds a zero-extended 64-bit value from them.

The finished instruction is presented with a valid/ready handshake and held there until it is taken. The output carries the opcode, the operand, the control fields, the total byte count (1 to 10) and an error flag for the reserved extension code. A one-cycle done strobe marks the cycle in which the result first appears. No input byte is accepted while a result is held.

Top module: `instr_prefix_decoder`

## Requirements
- R1: The first byte of an instruction is a prefix when its bits [2:0] equal 3'b111. A prefix drives the outputs as follows: bit 3 to `out_addr_ext`, bits [5:4] to `out_width` and bits [7:6] to `out_ext`. The next byte is then the opcode, whatever its low bits.
- R2: A first byte whose bits [2:0] are not 3'b111 is the opcode itself. In that case `out_addr_ext`, `out_width` and `out_ext` are all zero.
- R3: `in_has_operand` is sampled only with the opcode byte. When it is 1, exactly 2^`out_width` operand bytes follow (width 0/1/2/3 gives 1/2/4/8 bytes). When it is 0, no operand byte is taken.
- R4: Operand bytes are placed least-significant first, so the k-th operand byte lands in `out_operand[8k+7:8k]`. All bits above the received bytes are zero, and the operand is all zero when there is no operand.
- R5: `out_len` equals the prefix count (0 or 1) plus one plus the number of operand bytes. It is always between 1 and 10.
- R6: `out_done` is high for exactly one cycle: the first cycle in which `out_valid` is high after the last byte of an instruction is taken.
- R7: `out_err` is high while a result is presented whose `out_ext` equals 2'b10. Decoding of such an instruction still completes normally.
- R8: While `out_valid` is high, `in_ready` is low, input bytes are ignored and every output field stays stable. The cycle after `out_valid && out_ready`, `out_valid` is low and `in_ready` is high.
- R9: After reset, `out_valid` and `out_done` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Instruction stream byte |
| in_has_operand | input | 1 | Opcode byte carries an operand (sampled with the opcode) |
| out_valid | output | 1 | Decoded instruction is presented |
| out_ready | input | 1 | Consumer takes the decoded instruction |
| out_opcode | output | 8 | Opcode byte |
| out_operand | output | 64 | Assembled, zero-extended operand |
| out_addr_ext | output | 1 | Extended addressing mode select |
| out_width | output | 2 | Register/operand width code |
| out_ext | output | 2 | Extension-set select |
| out_len | output | 4 | Total instruction length in bytes |
| out_err | output | 1 | Reserved extension code decoded |
| out_done | output | 1 | One-cycle strobe when a result first appears |

## Verification
The bench targets several corner cases:
- An opcode that follows a prefix and itself has 111 in its low bits. A decoder that re-tests every byte for the prefix pattern would take this opcode as a second prefix and report the wrong length.
- The widest instruction, with an 8-byte operand, to check the 10-byte length and the top operand byte. A counter that is one short would leave the top byte zero or keep waiting for another byte.
- Random values on the operand flag during non-opcode bytes. A decoder that samples the flag at the wrong time would change the length.
- Junk bytes driven while a result is held. A decoder that leaks them in would corrupt the held fields or the next instruction.

// File: rtl/instr_prefix_decoder.sv
module instr_prefix_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  input  logic        in_has_operand,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_opcode,
  output logic [63:0] out_operand,
  output logic        out_addr_ext,
  output logic [1:0]  out_width,
  output logic [1:0]  out_ext,
  output logic [3:0]  out_len,
  output logic        out_err,
  output logic        out_done
);
  localparam logic [2:0] PFX_MARK = 3'b111;
  localparam logic [1:0] EXT_RSVD = 2'b10;

  typedef enum logic [1:0] {S_FIRST, S_OPC, S_OPR, S_HOLD} state_t;
  state_t state;

  logic [2:0] idx;
  logic [2:0] last_idx;
  logic       take;

  assign take      = in_valid && in_ready;
  assign in_ready  = (state != S_HOLD);
  assign out_valid = (state == S_HOLD);
  assign out_err   = out_valid && (out_ext == EXT_RSVD);
  assign last_idx  = 3'((4'd1 << out_width) - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_FIRST;
      out_opcode   <= '0;
      out_operand  <= '0;
      out_addr_ext <= 1'b0;
      out_width    <= '0;
      out_ext      <= '0;
      out_len      <= '0;
      out_done     <= 1'b0;
      idx          <= '0;
    end else begin
      out_done <= 1'b0;
      case (state)
        S_FIRST: if (take) begin
          out_operand <= '0;
          out_len     <= 4'd1;
          idx         <= '0;
          if (in_byte[2:0] == PFX_MARK) begin
            {out_ext, out_width, out_addr_ext} <= in_byte[7:3];
            state <= S_OPC;
          end else begin
            {out_ext, out_width, out_addr_ext} <= '0;
            out_opcode <= in_byte;
            if (in_has_operand) state <= S_OPR;
            else begin
              state    <= S_HOLD;
              out_done <= 1'b1;
            end
          end
        end
        S_OPC: if (take) begin
          out_opcode <= in_byte;
          out_len    <= 4'(out_len + 4'd1);
          if (in_has_operand) state <= S_OPR;
          else begin
            state    <= S_HOLD;
            out_done <= 1'b1;
          end
        end
        S_OPR: if (take) begin
          out_operand[{idx, 3'b000} +: 8] <= in_byte;
          out_len <= 4'(out_len + 4'd1);
          idx     <= 3'(idx + 3'd1);
          if (idx == last_idx) begin
            state    <= S_HOLD;
            out_done <= 1'b1;
          end
        end
        default: if (out_ready) state <= S_FIRST;
      endcase
    end
  end

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_opcode) && $stable(out_operand) && $stable(out_len)); // R8
  AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> out_valid && !$past(out_valid)); // R6
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len >= 4'd1 && out_len <= 4'd10); // R5
  AST_SHORT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_len == 4'd1 |-> {out_ext, out_width, out_addr_ext} == 5'd0 && out_operand == 64'd0); // R2
  AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_operand >> (7'd8 << out_width)) == 64'd0); // R4
endmodule

// File: tb/instr_prefix_decoder_test.sv
module instr_prefix_decoder_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_has_operand = 0, out_ready = 0;
  logic [7:0] in_byte = 0;
  logic in_ready, out_valid, out_addr_ext, out_err, out_done;
  logic [7:0] out_opcode;
  logic [63:0] out_operand;
  logic [1:0] out_width, out_ext;
  logic [3:0] out_len;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  instr_prefix_decoder uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_len(bit pf, bit hop, logic [1:0] w);
    return 4'((pf ? 1 : 0) + 1 + (hop ? (1 << w) : 0));
  endfunction

  function automatic logic [63:0] exp_opr(bit hop, logic [1:0] w, logic [63:0] v);
    logic [63:0] m;
    m = (w == 2'd3) ? '1 : ((64'd1 << (8 << w)) - 64'd1);
    return hop ? (v & m) : 64'd0;
  endfunction

  task automatic put(input logic [7:0] b, input logic hop);
    @(negedge clk);
    in_valid = 1; in_byte = b; in_has_operand = hop;
    @(posedge clk);
  endtask

  task automatic run(input bit pf, input logic [7:0] pb, input logic [7:0] opc, input bit hop, input logic [63:0] v);
    logic [1:0] w, e;
    logic a;
    logic [7:0] s_opc;
    logic [63:0] s_opr;
    int nb;
    w = pf ? pb[5:4] : 2'd0;
    e = pf ? pb[7:6] : 2'd0;
    a = pf ? pb[3] : 1'b0;
    if (pf) put(pb, 1'($urandom));
    put(opc, hop);
    nb = hop ? (1 << w) : 0;
    for (int i = 0; i < nb; i++) put(v[8*i +: 8], 1'($urandom));
    @(negedge clk);
    in_valid = 1; in_byte = 8'($urandom); in_has_operand = 1'($urandom);
    chk(out_valid === 1'b1, "R8 valid after last byte", 64'(out_valid), 1);
    chk(out_done === 1'b1, "R6 done pulse", 64'(out_done), 1);
    chk(out_opcode === opc, "R1/R2 opcode", 64'(out_opcode), 64'(opc));
    chk(out_addr_ext === a, pf ? "R1 addr mode" : "R2 addr mode", 64'(out_addr_ext), 64'(a));
    chk(out_width === w, pf ? "R1 width" : "R2 width", 64'(out_width), 64'(w));
    chk(out_ext === e, pf ? "R1 ext" : "R2 ext", 64'(out_ext), 64'(e));
    chk(out_operand === exp_opr(hop, w, v), "R4 operand", out_operand, exp_opr(hop, w, v));
    chk(out_len === exp_len(pf, hop, w), "R5/R3 length", 64'(out_len), 64'(exp_len(pf, hop, w)));
    chk(out_err === (e == 2'b10), "R7 err", 64'(out_err), 64'(e == 2'b10));
    s_opc = out_opcode; s_opr = out_operand;
    @(negedge clk);
    chk(out_done === 1'b0, "R6 done single cycle", 64'(out_done), 0);
    chk(in_ready === 1'b0, "R8 ready low while held", 64'(in_ready), 0);
    chk(out_opcode === s_opc && out_operand === s_opr, "R8 held stable", out_operand, s_opr);
    in_valid = 0; out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R8 release", {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 0 && out_done === 0 && in_ready === 1, "R9 reset state",
        {out_valid, out_done, in_ready}, 3'b001);
    rst_n = 1;
    run(0, 8'h00, 8'h42, 0, 0);
    run(0, 8'h00, 8'h10, 1, 64'hDEAD_BEEF_CAFE_F00D);
    run(1, 8'b11_11_1_111, 8'h7F, 1, 64'h8877_6655_4433_2211);
    run(1, 8'b10_01_0_111, 8'h3C, 1, 64'h0000_0000_0000_ABCD);
    run(1, 8'b00_10_1_111, 8'hF7, 0, 64'h1234);
    run(1, 8'b01_10_0_111, 8'h07, 1, 64'hFFFF_FFFF_9ABC_DEF0);
    for (int n = 0; n < 300; n++) begin
      logic [7:0] pb, op;
      bit pf;
      pf = 1'($urandom);
      pb = {5'($urandom), 3'b111};
      op = 8'($urandom);
      if (!pf && op[2:0] == 3'b111) op[0] = 1'b0;
      run(pf, pb, op, 1'($urandom), {$urandom, $urandom});
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule